// File: doc/BRIEF.md
# Receive Buffer with Threshold Interrupt Bid

This block stores the characters delivered by a serial receiver until the host reads them. Each stored word is 11 bits wide. The low eight bits are the character, and the upper three bits are the error flags the receiver attached to it. The buffer holds 256 words. In front of it sits a one-word holding register that is loaded whenever the receiver completes a character. The word in the holding register moves into the buffer as soon as a slot is free.

The number of filled slots is turned into an interrupt bid for an arbiter elsewhere in the chip. The bid value is the fill count minus one. A 2-bit threshold setting chooses the fill level at which bidding starts.

When the buffer and the holding register are both full and the receiver reports another start bit, a sticky overrun flag is raised. While the buffer stays full, newer characters overwrite the holding register. The stored words are never disturbed.

Top module: `rx_fifo_bid`

## Requirements
- R1: Words leave in the order they entered, unmodified (bits 7:0 data, bits 10:8 flags). Up to 256 words are held. `headWord` shows the oldest stored word whenever `empty` is low, and `full` is high exactly when 256 words are stored.
- R2: While `bidValid` is high, `bidLevel` equals the number of stored words minus one, so a single word gives 0 and a full buffer gives 255. While `bidValid` is low, `bidLevel` reads 0.
- R3: An empty buffer never raises `bidValid`, whatever the threshold setting.
- R4: `thrSel` sets where bidding starts. With 0, bidding starts at 1 or more stored words. With 1, it starts at 128 or more. With 2, it starts at 192 or more. With 3, it starts only at 256. The setting is applied combinationally to the current count.
- R5: A `charValid` pulse at a clock edge loads `charIn` into the holding register, and `holdFull` goes high after that edge. At the next edge the word moves into the buffer if a slot is free.
- R6: `overrun` is set after an edge at which `startDet` is high, `full` and `holdFull` are both high, and `rdEn` is low. A start bit in any other situation does not set it.
- R7: While the buffer is full, a new `charValid` replaces the holding register content and the stored words remain intact. A read of a full buffer moves the holding word in at the same edge.
- R8: `overrun` stays high until a `clrErr` pulse or reset clears it. If a clear and a new set occur at the same edge, the set wins.
- R9: `rdEn` while `empty` changes neither the count nor the pointers. In that case `headWord` keeps showing the last word read, or 0 if no word has been read since reset.
- R10: If a read and a move from the holding register occur at the same edge while the buffer is full, both are performed and the buffer stays full.
- R11: After reset the outputs are as follows: `empty` high, `full` and `holdFull` low, `bidValid` low, `bidLevel` 0, `overrun` low, and `headWord` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| charValid | input | 1 | Receiver has a completed character on `charIn` |
| charIn | input | 11 | Character and its three error flags |
| startDet | input | 1 | Receiver has seen a start bit |
| rdEn | input | 1 | Host reads and removes the head word |
| clrErr | input | 1 | Clears the overrun flag |
| thrSel | input | 2 | Bid start threshold select |
| headWord | output | 11 | Oldest stored word, or last word read when empty |
| full | output | 1 | 256 words stored |
| empty | output | 1 | No words stored |
| holdFull | output | 1 | Holding register occupied |
| bidValid | output | 1 | Interrupt bid active |
| bidLevel | output | 8 | Fill count minus one while bidding |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Several stimulus patterns are used, and each one targets a different kind of fault.

- A single write followed by reads into an empty buffer separates the two-stage path through the holding register from a direct path. It also exposes a head value that is lost on an empty read.
- A full fill with the threshold select swept exposes misplaced boundaries at 128, 192 and 256. It also exposes an off-by-one in the bid value.
- Start bits and overwrites of the holding register while full show whether overrun is set only under the full-and-held condition. They also show whether the stored words survive.
- A read at the same edge as the holding move at full tests that the count stays balanced.
- Long random runs with biased read and write rates catch ordering and count errors that the directed cases miss.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;
  typedef struct packed {
    logic push;   // move holding word into buffer
    logic pop;    // remove head word
    logic load;   // load holding register
    logic empty;  // buffer has no words
  } strobe_t;
endpackage

// File: rtl/rxfifo_ctrl.sv
module rxfifo_ctrl
  import rxfifo_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charValid,
  input  logic              startDet,
  input  logic              rdEn,
  input  logic              clrErr,
  input  logic [1:0]        thrSel,
  output strobe_t           stb,
  output logic              full,
  output logic              empty,
  output logic              holdFull,
  output logic              bidValid,
  output logic [ADDR_W-1:0] bidLevel,
  output logic              overrun
);
  localparam logic [CNT_W-1:0] DepthC = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HalfC  = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] TqC    = CNT_W'((DEPTH / 4) * 3);
  localparam logic [CNT_W-1:0] OneC   = CNT_W'(1);

  logic [CNT_W-1:0] fillCnt;
  logic [CNT_W-1:0] cntM1;
  logic [CNT_W-1:0] thrLevel;
  logic             holdV;
  logic             ovrQ;
  logic             isFull, isEmpty, doPop, doPush, ovrSet;

  always_comb begin
    isFull  = (fillCnt == DepthC);
    isEmpty = (fillCnt == '0);
    doPop   = rdEn && !isEmpty;
    doPush  = holdV && (!isFull || doPop);
    ovrSet  = startDet && isFull && holdV && !doPop;
    unique case (thrSel)
      2'd0:    thrLevel = OneC;
      2'd1:    thrLevel = HalfC;
      2'd2:    thrLevel = TqC;
      default: thrLevel = DepthC;
    endcase
    cntM1 = fillCnt - OneC;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
      holdV   <= 1'b0;
      ovrQ    <= 1'b0;
    end else begin
      unique case ({doPush, doPop})
        2'b10:   fillCnt <= fillCnt + OneC;
        2'b01:   fillCnt <= fillCnt - OneC;
        default: fillCnt <= fillCnt;
      endcase
      if (charValid)   holdV <= 1'b1;
      else if (doPush) holdV <= 1'b0;
      ovrQ <= (ovrQ && !clrErr) || ovrSet;
    end
  end

  assign stb.push  = doPush;
  assign stb.pop   = doPop;
  assign stb.load  = charValid;
  assign stb.empty = isEmpty;

  assign full     = isFull;
  assign empty    = isEmpty;
  assign holdFull = holdV;
  assign bidValid = !isEmpty && (fillCnt >= thrLevel);
  assign bidLevel = bidValid ? cntM1[ADDR_W-1:0] : '0;
  assign overrun  = ovrQ;
endmodule

// File: rtl/rxfifo_dp.sv
module rxfifo_dp
  import rxfifo_pkg::*;
#(
  parameter int WORD_W = 11,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] charIn,
  output logic [WORD_W-1:0] headWord
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [WORD_W-1:0] holdReg;
  logic [WORD_W-1:0] lastWord;

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= holdReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      holdReg  <= '0;
      lastWord <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtr + ADDR_W'(1);
      if (stb.pop) begin
        rdPtr    <= rdPtr + ADDR_W'(1);
        lastWord <= mem[rdPtr];
      end
      if (stb.load) holdReg <= charIn;
    end
  end

  assign headWord = stb.empty ? lastWord : mem[rdPtr];
endmodule

// File: rtl/rx_fifo_bid.sv
module rx_fifo_bid
  import rxfifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 3,
  parameter int DEPTH  = 256,
  localparam int WORD_W = DATA_W + FLAG_W,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charValid,
  input  logic [WORD_W-1:0] charIn,
  input  logic              startDet,
  input  logic              rdEn,
  input  logic              clrErr,
  input  logic [1:0]        thrSel,
  output logic [WORD_W-1:0] headWord,
  output logic              full,
  output logic              empty,
  output logic              holdFull,
  output logic              bidValid,
  output logic [ADDR_W-1:0] bidLevel,
  output logic              overrun
);
  strobe_t stb;

  rxfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .charValid(charValid), .startDet(startDet),
    .rdEn(rdEn), .clrErr(clrErr), .thrSel(thrSel), .stb(stb),
    .full(full), .empty(empty), .holdFull(holdFull),
    .bidValid(bidValid), .bidLevel(bidLevel), .overrun(overrun)
  );

  rxfifo_dp #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .charIn(charIn), .headWord(headWord)
  );
endmodule

// File: rtl/rxfifo_chk.sv
module rxfifo_chk #(
  parameter int WORD_W = 11,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              charValid,
  input logic              startDet,
  input logic              rdEn,
  input logic              clrErr,
  input logic [WORD_W-1:0] headWord,
  input logic              full,
  input logic              empty,
  input logic              holdFull,
  input logic              bidValid,
  input logic [ADDR_W-1:0] bidLevel,
  input logic              overrun
);
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty)); // R1
  AST_FULL_BID: assert property (@(posedge clk) disable iff (!rstN)
    full |-> (bidValid && bidLevel == ADDR_W'(DEPTH - 1))); // R2
  AST_EMPTY_NO_BID: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !bidValid); // R3
  AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    charValid |=> holdFull); // R5
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (!overrun ##1 overrun) |-> $past(startDet && full && holdFull && !rdEn)); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !clrErr) |=> overrun); // R8
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (empty && rdEn && !holdFull) |=> (empty && $stable(headWord))); // R9
  AST_FULL_RW: assert property (@(posedge clk) disable iff (!rstN)
    (full && rdEn && holdFull) |=> full); // R10
endmodule

bind rx_fifo_bid rxfifo_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .charValid(charValid), .startDet(startDet),
  .rdEn(rdEn), .clrErr(clrErr), .headWord(headWord), .full(full),
  .empty(empty), .holdFull(holdFull), .bidValid(bidValid),
  .bidLevel(bidLevel), .overrun(overrun)
);

// File: tb/sim_rx_fifo_bid.sv
`timescale 1ns/1ps
module sim_rx_fifo_bid;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rstN;
  logic        charValid, startDet, rdEn, clrErr;
  logic [10:0] charIn;
  logic [1:0]  thrSel;
  logic [10:0] headWord;
  logic        full, empty, holdFull, bidValid, overrun;
  logic [7:0]  bidLevel;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [10:0] mq[$];
  logic [10:0] mHold, mLast;
  logic        mHoldV, mOvr;

  always #10 clk = ~clk;

  rx_fifo_bid u0 (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charIn(charIn),
    .startDet(startDet), .rdEn(rdEn), .clrErr(clrErr), .thrSel(thrSel),
    .headWord(headWord), .full(full), .empty(empty), .holdFull(holdFull),
    .bidValid(bidValid), .bidLevel(bidLevel), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expBid(input int n, input logic [1:0] sel);
    int thr;
    case (sel)
      2'd0: thr = 1;
      2'd1: thr = DEPTH / 2;
      2'd2: thr = (DEPTH / 4) * 3;
      default: thr = DEPTH;
    endcase
    return (n > 0) && (n >= thr);
  endfunction

  function automatic int expLevel(input int n, input logic [1:0] sel);
    return expBid(n, sel) ? ((n - 1) & 8'hFF) : 0;
  endfunction

  task automatic compareAll();
    int n = mq.size();
    check(empty == (n == 0), "R1 empty", empty, n == 0);
    check(full == (n == DEPTH), "R1 full", full, n == DEPTH);
    if (n > 0) check(headWord == mq[0], "R1 head", headWord, mq[0]);
    else       check(headWord == mLast, "R9 head when empty", headWord, mLast);
    check(holdFull == mHoldV, "R5 holdFull", holdFull, mHoldV);
    check(bidValid == expBid(n, thrSel), "R4 bidValid", bidValid, expBid(n, thrSel));
    check(bidLevel == expLevel(n, thrSel), "R2 bidLevel", bidLevel, expLevel(n, thrSel));
    check(overrun == mOvr, "R8 overrun", overrun, mOvr);
  endtask

  // drive one cycle from a negedge, update the model, compare at next negedge
  task automatic cyc(input bit cv, input logic [10:0] ci, input bit sd,
                     input bit rd, input bit clr, input logic [1:0] sel);
    int n;
    bit pop, push, ovrSet, isFull;
    charValid = cv; charIn = ci; startDet = sd; rdEn = rd; clrErr = clr; thrSel = sel;
    n = mq.size();
    isFull = (n == DEPTH);
    pop = rd && (n > 0);
    push = mHoldV && (!isFull || pop);
    ovrSet = sd && isFull && mHoldV && !pop;
    if (pop) mLast = mq.pop_front();
    if (push) mq.push_back(mHold);
    if (cv) begin mHold = ci; mHoldV = 1'b1; end
    else if (push) mHoldV = 1'b0;
    mOvr = (mOvr && !clr) || ovrSet;
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [10:0] overw;
    void'($urandom(32'd7));
    mq.delete(); mHold = '0; mLast = '0; mHoldV = 1'b0; mOvr = 1'b0;
    rstN = 1'b0; charValid = 0; charIn = '0; startDet = 0; rdEn = 0; clrErr = 0; thrSel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    check(empty && !full && !holdFull, "R11 flags", {empty, full, holdFull}, 3'b100);
    check(!bidValid && bidLevel == 0, "R11 bid", bidLevel, 0);
    check(!overrun, "R11 overrun", overrun, 0);
    check(headWord == 0, "R11 headWord", headWord, 0);

    // R5 two-stage entry
    cyc(1, 11'h5A3, 0, 0, 0, 0);
    check(holdFull && empty, "R5 held not stored", {holdFull, empty}, 2'b11);
    cyc(0, 0, 0, 0, 0, 0);
    check(!empty && headWord == 11'h5A3 && bidLevel == 0, "R5 stored", headWord, 11'h5A3);
    // R9 empty reads
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    check(empty && headWord == 11'h5A3, "R9 empty read keeps head", headWord, 11'h5A3);
    // R3 empty never bids
    for (int s = 0; s < 4; s++) begin
      cyc(0, 0, 0, 0, 0, 2'(s));
      check(!bidValid, "R3 empty bid", bidValid, 0);
    end

    // fill with threshold sweep (R4 boundaries checked each cycle by model)
    for (int i = 0; i < DEPTH + 1; i++) cyc(1, 11'($urandom), 0, 0, 0, 2'(i % 4));
    cyc(0, 0, 0, 0, 0, 3);
    check(full && holdFull, "R7 full and held", {full, holdFull}, 2'b11);
    check(bidValid && bidLevel == 255, "R2 full bid", bidLevel, 255);
    // R6 start bit while reading does not set overrun
    cyc(0, 0, 1, 1, 0, 3);
    check(!overrun && full, "R6 no overrun with read", overrun, 0);
    // R7 overwrite holding
    cyc(1, 11'h123, 0, 0, 0, 3);
    overw = 11'h7EE;
    cyc(1, overw, 0, 0, 0, 3);
    // R6 overrun
    cyc(0, 0, 1, 0, 0, 3);
    check(overrun, "R6 overrun set", overrun, 1);
    // R10 simultaneous read and move at full
    cyc(0, 0, 0, 1, 0, 3);
    check(full && !holdFull, "R10 stays full", full, 1);
    check(overrun, "R8 sticky", overrun, 1);
    cyc(0, 0, 0, 0, 0, 3);
    check(overrun, "R8 sticky idle", overrun, 1);
    // R8 clear vs set same edge: set wins
    cyc(1, 11'h0F0, 0, 0, 0, 3);
    cyc(0, 0, 1, 0, 1, 3);
    check(overrun, "R8 set beats clear", overrun, 1);
    cyc(0, 0, 0, 0, 1, 3);
    check(!overrun, "R8 cleared", overrun, 0);
    // drain everything, model verifies order and the overwritten word (R7)
    for (int i = 0; i < DEPTH + 4; i++) cyc(0, 0, 0, 1, 0, 2'(i % 4));
    check(empty && !holdFull, "R1 drained", empty, 1);

    // random phases
    for (int ph = 0; ph < 12; ph++) begin
      int wrP = (ph % 3 == 0) ? 90 : (ph % 3 == 1) ? 50 : 20;
      int rdP = (ph % 3 == 0) ? 15 : (ph % 3 == 1) ? 50 : 85;
      for (int k = 0; k < 700; k++)
        cyc(($urandom % 100) < wrP, 11'($urandom), ($urandom % 100) < 30,
            ($urandom % 100) < rdP, ($urandom % 100) < 3, 2'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule